// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds two channels that sit beside a free-running 16-bit counter. Each
channel is either an output compare, driving a pin from a comparison of the counter
against its 16-bit capture/compare value, or an input capture, latching the counter
when a chosen edge arrives. In capture mode a channel takes its signal from its own
timer input, from the other channel's timer input, or, for channel 2 only, from an
internal trigger.

Software reaches the channels through a byte-wide write/read port. Each channel has its
own mode byte. The two channels share one enable byte, in which each channel has an
enable bit and a polarity bit. The capture/compare values and the sticky capture flags
are reached through the same port. The counter is an input, so one counter can serve
several channel pairs.

Top module: `cc_pair`

Address map: 0 = channel 1 mode, 1 = channel 2 mode, 2 = enable byte, 3 = capture flags
(bit 0 channel 1, bit 1 channel 2), 4/5 = channel 1 value low/high byte, 6/7 = channel 2
value low/high byte.

## Requirements
- R1: After reset, every address reads 0x00. Both pins are 0 and both capture flags are 0, so each channel starts as a disabled output.
- R2: The mode byte's bits [1:0] select the channel's function: 00 output compare, 01 capture from its own timer input, 10 capture from the other channel's timer input. Edges on inputs that are not selected cause no capture.
- R3: Selection 11 on channel 2 captures from the trigger input, but only while `trig_sel_ok` is 1. On channel 1, selection 11 never captures.
- R4: A write to a mode byte updates the selection only while that channel's enable bit is 0. Otherwise the selection keeps its value. Mode bits [7:2] read as 0.
- R5: In output mode with the enable bit set, the pin equals (count >= value) when polarity is 0, and the inverse of that when polarity is 1.
- R6: A channel whose enable bit is 0, or that is not in output mode, drives its pin to 0.
- R7: In capture mode with the enable bit set, polarity 0 captures on a rising edge of the selected input and polarity 1 captures on a falling edge.
- R8: In capture mode with the enable bit at 0, edges leave the value and the flag unchanged.
- R9: A capture sets the channel's flag, and the flag stays set. Writing address 3 clears each flag whose data bit is 0, and leaves set each flag whose data bit is 1.
- R10: The enable byte holds channel 1 enable in bit 0, channel 1 polarity in bit 1, channel 2 enable in bit 4 and channel 2 polarity in bit 5. Its other bits read as 0.
- R11: An input change that happens between two clock edges loads the counter value present at the next edge. The value bytes can also be written and read back by software.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| ch1_in | input | 1 | Filtered timer input of channel 1 |
| ch2_in | input | 1 | Filtered timer input of channel 2 |
| trig_in | input | 1 | Internal trigger signal |
| trig_sel_ok | input | 1 | High when an internal trigger source is selected |
| count | input | 16 | Free-running counter value |
| cmp_pin | output | 2 | Compare output pins, bit 0 = channel 1 |
| cap_flag | output | 2 | Sticky capture flags, bit 0 = channel 1 |

## Verification
The compare output is swept over both channels, both modes, both enable levels and both
polarities. The counter is placed at one below, equal to and one above each of three
compare values, including both ends of the range, which separates a >= comparison from
a > comparison and from a wrong inversion.

Capture is swept over every selection code, polarity, enable level and trigger-valid
level on each channel. Before the selected source rises and then falls, every input that
is not selected is raised. This shows which input is wired to each code and which of the
two edges loads the counter, because the two edges use different counter values.

Separate sequences check the write lock, the layout of the enable byte and the
write-zero-to-clear rule for the flags.

// File: rtl/cc_pair_pkg.sv
package cc_pair_pkg;

    localparam int NUM_CH = 2;

    // Register addresses
    localparam int A_MODE_BASE = 0;
    localparam int A_ENABLE    = 2;
    localparam int A_FLAGS     = 3;
    localparam int A_CCR_BASE  = 4;

    // Channel function selection carried in mode bits [1:0]
    typedef enum logic [1:0] {
        SEL_OUTPUT    = 2'b00,
        SEL_OWN       = 2'b01,
        SEL_NEIGHBOUR = 2'b10,
        SEL_ALT       = 2'b11
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic en;
        logic pol;
    } ch_cfg_t;

    function automatic logic compare_active(input logic [15:0] cnt, input logic [15:0] cmp);
        return cnt >= cmp;
    endfunction

endpackage

// File: rtl/cc_pair_regs.sv
module cc_pair_regs
    import cc_pair_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ccr_val,
    input  logic [NUM_CH-1:0]             flags,
    output ch_cfg_t [NUM_CH-1:0]          cfg,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int BYTES     = CNT_W / DATA_W;
    localparam int EN_STRIDE = DATA_W / NUM_CH;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_cfg
            sel_e sel_r;
            logic en_r;
            logic pol_r;
            logic mode_hit;
            logic enable_hit;

            assign mode_hit   = wr_en && (addr == ADDR_W'(A_MODE_BASE + c));
            assign enable_hit = wr_en && (addr == ADDR_W'(A_ENABLE));

            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_r <= SEL_OUTPUT;
                    en_r  <= 1'b0;
                    pol_r <= 1'b0;
                end else begin
                    if (mode_hit && !en_r) begin
                        sel_r <= sel_e'(wr_data[1:0]);
                    end
                    if (enable_hit) begin
                        en_r  <= wr_data[EN_STRIDE*c];
                        pol_r <= wr_data[EN_STRIDE*c+1];
                    end
                end
            end

            assign cfg[c] = '{sel: sel_r, en: en_r, pol: pol_r};

            // R4: selection is frozen while the channel is enabled
            a_r4_sel_locked: assert property (@(posedge clk) disable iff (rst)
                (mode_hit && cfg[c].en) |=> $stable(cfg[c].sel));
            // R4: selection follows the write while disabled
            a_r4_sel_free: assert property (@(posedge clk) disable iff (rst)
                (mode_hit && !cfg[c].en) |=> (2'(cfg[c].sel) == $past(wr_data[1:0])));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (addr == ADDR_W'(A_MODE_BASE + k)) begin
                rd_data[1:0] = cfg[k].sel;
            end
            if (addr == ADDR_W'(A_ENABLE)) begin
                rd_data[EN_STRIDE*k]   = cfg[k].en;
                rd_data[EN_STRIDE*k+1] = cfg[k].pol;
            end
            if (addr == ADDR_W'(A_FLAGS)) begin
                rd_data[k] = flags[k];
            end
            for (int b = 0; b < BYTES; b++) begin
                if (addr == ADDR_W'(A_CCR_BASE + k*BYTES + b)) begin
                    rd_data = ccr_val[k][b*DATA_W +: DATA_W];
                end
            end
        end
    end

    function automatic logic [DATA_W-1:0] enable_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            m[EN_STRIDE*k]   = 1'b1;
            m[EN_STRIDE*k+1] = 1'b1;
        end
        return m;
    endfunction

    // R10: spare bits of the enable byte read as zero
    a_r10_enable_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(A_ENABLE)) |-> ((rd_data & ~enable_mask()) == '0));

endmodule

// File: rtl/cc_pair_chan.sv
module cc_pair_chan
    import cc_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ch_cfg_t                    cfg,
    input  logic                       own_in,
    input  logic                       nbr_in,
    input  logic                       alt_in,
    input  logic                       alt_ok,
    input  logic [CNT_W-1:0]           count,
    input  logic [CNT_W/DATA_W-1:0]    byte_wr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       flag_clr,
    output logic [CNT_W-1:0]           ccr,
    output logic                       flag,
    output logic                       pin
);
    localparam int BYTES = CNT_W / DATA_W;

    logic src;
    logic src_ok;
    logic src_q;
    logic edge_hit;
    logic capture;
    logic ref_lvl;

    // Input routing by selection code
    always_comb begin
        src    = 1'b0;
        src_ok = 1'b0;
        case (cfg.sel)
            SEL_OWN: begin
                src    = own_in;
                src_ok = 1'b1;
            end
            SEL_NEIGHBOUR: begin
                src    = nbr_in;
                src_ok = 1'b1;
            end
            SEL_ALT: begin
                src    = alt_in;
                src_ok = alt_ok;
            end
            default: begin
                src    = 1'b0;
                src_ok = 1'b0;
            end
        endcase
    end

    // Edge detection against the previous sample
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= 1'b0;
        end else begin
            src_q <= src;
        end
    end

    assign edge_hit = cfg.pol ? (src_q & ~src) : (~src_q & src);
    assign capture  = edge_hit & src_ok & cfg.en;

    // Capture/compare value: capture has priority over software writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ccr <= '0;
        end else if (capture) begin
            ccr <= count;
        end else begin
            for (int b = 0; b < BYTES; b++) begin
                if (byte_wr[b]) begin
                    ccr[b*DATA_W +: DATA_W] <= wr_data;
                end
            end
        end
    end

    // Sticky flag: a capture wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (capture) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // Output compare
    assign ref_lvl = compare_active(16'(count), 16'(ccr));
    assign pin     = (cfg.sel == SEL_OUTPUT && cfg.en) ? (ref_lvl ^ cfg.pol) : 1'b0;

    // R6: pin idles low unless enabled in output mode
    a_r6_pin_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en || cfg.sel != SEL_OUTPUT) |-> !pin);
    // R5: active-high output stays low below the compare value
    a_r5_below_low: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel == SEL_OUTPUT && cfg.en && !cfg.pol && count < ccr) |-> !pin);
    // R8: a disabled channel never captures
    a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && byte_wr == '0) |=> $stable(ccr));
    // R9: flag is sticky until cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
    // R9: a clear on a disabled channel takes effect
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cfg.en) |=> !flag);
    // R11: a fresh flag comes with the counter of the previous cycle
    a_r11_capture_value: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (ccr == $past(count)));
    // R7: rising edge on own input captures with polarity 0
    a_r7_rise_own: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.sel == SEL_OWN && !cfg.pol && $rose(own_in) && $stable(cfg)) |=> flag);

endmodule

// File: rtl/cc_pair.sv
module cc_pair
    import cc_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 ch1_in,
    input  logic                 ch2_in,
    input  logic                 trig_in,
    input  logic                 trig_sel_ok,
    input  logic [CNT_W-1:0]     count,
    output logic [NUM_CH-1:0]    cmp_pin,
    output logic [NUM_CH-1:0]    cap_flag
);
    localparam int BYTES = CNT_W / DATA_W;

    ch_cfg_t [NUM_CH-1:0]         cfg;
    logic [NUM_CH-1:0][CNT_W-1:0] ccr_val;
    logic [NUM_CH-1:0]            tin_v;

    assign tin_v = {ch2_in, ch1_in};

    cc_pair_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .ccr_val (ccr_val),
        .flags   (cap_flag),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    genvar c, b;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic             alt_src;
            logic             alt_valid;
            logic [BYTES-1:0] byte_wr;
            logic             flag_clr;

            // Only the last channel reaches the internal trigger
            if (c == NUM_CH - 1) begin : g_trig
                assign alt_src   = trig_in;
                assign alt_valid = trig_sel_ok;
            end else begin : g_reserved
                assign alt_src   = 1'b0;
                assign alt_valid = 1'b0;
            end

            for (b = 0; b < BYTES; b++) begin : g_bw
                assign byte_wr[b] = wr_en && (addr == ADDR_W'(A_CCR_BASE + c*BYTES + b));
            end

            assign flag_clr = wr_en && (addr == ADDR_W'(A_FLAGS)) && !wr_data[c];

            cc_pair_chan #(
                .CNT_W  (CNT_W),
                .DATA_W (DATA_W)
            ) u_chan (
                .clk      (clk),
                .rst      (rst),
                .cfg      (cfg[c]),
                .own_in   (tin_v[c]),
                .nbr_in   (tin_v[NUM_CH-1-c]),
                .alt_in   (alt_src),
                .alt_ok   (alt_valid),
                .count    (count),
                .byte_wr  (byte_wr),
                .wr_data  (wr_data),
                .flag_clr (flag_clr),
                .ccr      (ccr_val[c]),
                .flag     (cap_flag[c]),
                .pin      (cmp_pin[c])
            );
        end
    endgenerate

    // R3: channel 2 in trigger mode never captures without a valid trigger source
    a_r3_trig_gated: assert property (@(posedge clk) disable iff (rst)
        (cfg[NUM_CH-1].sel == SEL_ALT && !trig_sel_ok && !cap_flag[NUM_CH-1])
        |=> !cap_flag[NUM_CH-1]);

endmodule

// File: tb/cc_pair_bench.sv
module cc_pair_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        ch1_in = 1'b0;
    logic        ch2_in = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_sel_ok = 1'b0;
    logic [15:0] count = '0;
    logic [1:0]  cmp_pin;
    logic [1:0]  cap_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cc_pair u_cc_pair (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .ch1_in      (ch1_in),
        .ch2_in      (ch2_in),
        .trig_in     (trig_in),
        .trig_sel_ok (trig_sel_ok),
        .count       (count),
        .cmp_pin     (cmp_pin),
        .cap_flag    (cap_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_ccr(input int ch, output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        rd(3'(4 + 2*ch), lo);
        rd(3'(5 + 2*ch), hi);
        v = {hi, lo};
    endtask

    task automatic set_src(input int src, input logic val);
        case (src)
            0: ch1_in = val;
            1: ch2_in = val;
            2: trig_in = val;
            default: ;
        endcase
    endtask

    initial begin
        logic [7:0]  d;
        logic [15:0] v16;
        int          idx;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset read", d, 0);
        end
        check("R1 pins", cmp_pin, 0);
        check("R1 flags", cap_flag, 0);

        // R10: enable byte layout
        wr(3'd2, 8'hFF);
        rd(3'd2, d);
        check("R10 enable layout", d, 8'h33);
        wr(3'd2, 8'h00);
        rd(3'd2, d);
        check("R10 enable cleared", d, 8'h00);

        // R4: write lock on the selection
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h02);
        rd(3'd0, d);
        check("R4 locked ch1", d, 8'h00);
        wr(3'd2, 8'h10);
        wr(3'd1, 8'h01);
        rd(3'd1, d);
        check("R4 locked ch2", d, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h02);
        rd(3'd0, d);
        check("R4 unlocked ch1", d, 8'h02);
        wr(3'd1, 8'hFE);
        rd(3'd1, d);
        check("R4 unlocked ch2 upper bits zero", d, 8'h02);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);

        // R11: software access to value bytes
        wr(3'd6, 8'hEF);
        wr(3'd7, 8'hBE);
        rd_ccr(1, v16);
        check("R11 value readback", v16, 16'hBEEF);

        // R5 / R6: output compare sweep
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int en = 0; en < 2; en++) begin
                    for (int pol = 0; pol < 2; pol++) begin
                        for (int k = 0; k < 3; k++) begin
                            logic [15:0] cv;
                            cv = (k == 0) ? 16'h0000 : (k == 1) ? 16'h4A5C : 16'hFFFF;
                            wr(3'd2, 8'h00);
                            wr(3'(ch), 8'(sel));
                            wr(3'(4 + 2*ch), cv[7:0]);
                            wr(3'(5 + 2*ch), cv[15:8]);
                            wr(3'd2, 8'((en << (4*ch)) | (pol << (4*ch + 1))));
                            for (int j = 0; j < 5; j++) begin
                                logic [15:0] cnt;
                                logic        exp;
                                case (j)
                                    0: cnt = cv - 16'd1;
                                    1: cnt = cv;
                                    2: cnt = cv + 16'd1;
                                    3: cnt = 16'h0000;
                                    default: cnt = 16'hFFFF;
                                endcase
                                count = cnt;
                                #1;
                                if (sel == 0 && en == 1) begin
                                    exp = (cnt >= cv) ^ (pol == 1);
                                    check("R5 compare pin", cmp_pin[ch], exp);
                                end else begin
                                    check("R6 pin idle", cmp_pin[ch], 0);
                                end
                                check("R6 other pin idle", cmp_pin[1-ch], 0);
                            end
                        end
                    end
                end
            end
        end

        // R2 / R3 / R7 / R8 / R11: capture sweep
        idx = 0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int en = 0; en < 2; en++) begin
                        for (int tv = 0; tv < 2; tv++) begin
                            logic [15:0] x1;
                            logic [15:0] x2;
                            logic [15:0] exp_v;
                            logic        valid;
                            logic        rise_cap;
                            logic        fall_cap;
                            int          src;
                            string       tag;

                            x1 = 16'h1000 + 16'(idx * 3);
                            x2 = 16'h8000 + 16'(idx * 5);
                            idx++;
                            if (sel == 1)      src = ch;
                            else if (sel == 2) src = 1 - ch;
                            else if (sel == 3) src = (ch == 1) ? 2 : 3;
                            else               src = 3;
                            valid = (sel == 1) || (sel == 2) || (sel == 3 && ch == 1 && tv == 1);
                            if (en == 0)       tag = "R8";
                            else if (sel == 3) tag = "R3";
                            else if (sel == 0) tag = "R2";
                            else               tag = "R7";

                            wr(3'd2, 8'h00);
                            ch1_in = 1'b0;
                            ch2_in = 1'b0;
                            trig_in = 1'b0;
                            trig_sel_ok = (tv == 1);
                            wr(3'(ch), 8'(sel));
                            wr(3'(4 + 2*ch), 8'h00);
                            wr(3'(5 + 2*ch), 8'h00);
                            wr(3'd3, 8'h00);
                            wr(3'd2, 8'((en << (4*ch)) | (pol << (4*ch + 1))));

                            // Unselected inputs toggle first
                            count = x1 ^ 16'h00FF;
                            if (src != 0) ch1_in = 1'b1;
                            if (src != 1) ch2_in = 1'b1;
                            if (src != 2) trig_in = 1'b1;
                            @(negedge clk);
                            check("R2 unselected inputs ignored", cap_flag[ch], 0);

                            count = x1;
                            set_src(src, 1'b1);
                            @(negedge clk);
                            rise_cap = valid && (en == 1) && (pol == 0);
                            check({tag, " rising edge flag"}, cap_flag[ch], rise_cap);

                            count = x2;
                            set_src(src, 1'b0);
                            @(negedge clk);
                            fall_cap = valid && (en == 1) && (pol == 1);
                            exp_v = fall_cap ? x2 : (rise_cap ? x1 : 16'h0000);
                            rd_ccr(ch, v16);
                            check({tag, " R11 captured value"}, v16, exp_v);
                            check("R11 flag after edges", cap_flag[ch], rise_cap | fall_cap);
                        end
                    end
                end
            end
        end

        // R9: flag stickiness and clear rule
        wr(3'd2, 8'h00);
        ch1_in = 1'b0;
        ch2_in = 1'b0;
        trig_in = 1'b0;
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h01);
        count = 16'h2222;
        ch1_in = 1'b1;
        @(negedge clk);
        check("R9 flag set", cap_flag[0], 1);
        repeat (3) @(negedge clk);
        check("R9 flag sticky", cap_flag[0], 1);
        wr(3'd3, 8'hFF);
        check("R9 write one keeps flag", cap_flag[0], 1);
        ch1_in = 1'b0;
        wr(3'd3, 8'h02);
        check("R9 write zero clears", cap_flag[0], 0);
        rd(3'd3, d);
        check("R9 flag byte", d, 8'h00);
        rd_ccr(0, v16);
        check("R11 value after flag test", v16, 16'h2222);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule